// File: doc/BRIEF.md
# Grouped-Function Byte ALU

This block is a purely combinational arithmetic and logic unit for byte-wide data. It takes two operands and a six-bit operation code. The code is split into a three-bit group field and a three-bit function field that selects one of eight entries inside that group. Group 0 holds the bitwise logic operations. Group 1 holds the arithmetic operations. Group 2 holds one-bit shifts, one-bit rotates and negation. Groups 3 to 7 and every reserved slot are no-ops.

The block drives a primary result C and a secondary result D. Each result has its own write enable, so the surrounding datapath knows which registers to update. Only multiply produces D: it returns the full double-width product, with the low byte on C and the high byte on D. Divide has a code but is disabled, and it behaves exactly like a reserved code. There is no clock and no internal state. Each of the three groups is decoded by its own unit, and a group selector chooses among them.

Top module: `alu8_grouped`

## Requirements
- R1: In group 0, functions 0 to 6 set C to A or B, not(A and B), not(A or B), A and B, not(A xor B), A xor B, and not A. c_we is 1 and d_we is 0.
- R2: Group 1 function 4 (add) gives C = (A + B) mod 256, with c_we=1 and d_we=0.
- R3: Group 1 function 3 (subtract) gives C = (A − B) mod 256, with c_we=1 and d_we=0.
- R4: Group 1 function 2 (multiply) gives C = low byte of A×B and D = high byte, with c_we=1 and d_we=1. No other code raises d_we.
- R5: Group 1 function 0 shifts A right by one bit and keeps bit 7, so C = {A[7], A[7:1]}. c_we=1.
- R6: Group 2 function 0 rotates A left by one bit: C = {A[6:0], A[7]}. Function 1 rotates A right by one bit: C = {A[0], A[7:1]}. c_we=1 in both cases.
- R7: Group 2 function 2 shifts A right logically: C = {0, A[7:1]}. Function 3 shifts A left: C = {A[6:0], 0}. c_we=1 in both cases.
- R8: Group 2 function 4 negates A: C = (0 − A) mod 256, with c_we=1.
- R9: The divide code (group 1, function 1) writes nothing. c_we=0, d_we=0, and C and D are both 0.
- R10: Reserved functions (group 0 function 7, group 1 functions 5 to 7, group 2 functions 5 to 7) and every function in groups 3 to 7 write nothing. Both enables are 0 and C=D=0.
- R11: Whenever d_we is 0, D is 0. Whenever c_we is 0, C is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_grp | input | 3 | Operation group field |
| op_fn | input | 3 | Function field within the group |
| opnd_a | input | 8 | Operand A (the only source for unary operations) |
| opnd_b | input | 8 | Operand B |
| res_c | output | 8 | Primary result |
| res_d | output | 8 | Secondary result (high byte of the product) |
| c_we | output | 1 | C holds a result to be written |
| d_we | output | 1 | D holds a result to be written |

## Verification
Every one of the 64 codes is tried with operands chosen to expose a different fault. 0x00/0xFF separates the inverting logic functions from the plain ones. 0xA5/0x3C makes each logic function give a distinct byte. Operand pairs that carry or borrow across bit 7 show whether add and subtract wrap. 0x80 and 0x01 separate arithmetic from logical shifts and rotates from shifts. Large multiplicands such as 0xFF×0xFF and 0x10×0x10 exercise the high byte of the product. A pseudo-random sweep over all codes then confirms that the no-op and divide codes hold both enables low whatever the operands are.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int GRP_W = 3;
    localparam int FN_W  = 3;

    localparam logic [GRP_W-1:0] GRP_LOGIC = 3'd0;
    localparam logic [GRP_W-1:0] GRP_ARITH = 3'd1;
    localparam logic [GRP_W-1:0] GRP_SHIFT = 3'd2;

    // group 0 functions
    localparam logic [FN_W-1:0] FN_OR   = 3'd0;
    localparam logic [FN_W-1:0] FN_NAND = 3'd1;
    localparam logic [FN_W-1:0] FN_NOR  = 3'd2;
    localparam logic [FN_W-1:0] FN_AND  = 3'd3;
    localparam logic [FN_W-1:0] FN_XNOR = 3'd4;
    localparam logic [FN_W-1:0] FN_XOR  = 3'd5;
    localparam logic [FN_W-1:0] FN_NOT  = 3'd6;

    // group 1 functions
    localparam logic [FN_W-1:0] FN_ASR  = 3'd0;
    localparam logic [FN_W-1:0] FN_DIV  = 3'd1;
    localparam logic [FN_W-1:0] FN_MUL  = 3'd2;
    localparam logic [FN_W-1:0] FN_SUB  = 3'd3;
    localparam logic [FN_W-1:0] FN_ADD  = 3'd4;

    // group 2 functions
    localparam logic [FN_W-1:0] FN_ROL  = 3'd0;
    localparam logic [FN_W-1:0] FN_ROR  = 3'd1;
    localparam logic [FN_W-1:0] FN_LSR  = 3'd2;
    localparam logic [FN_W-1:0] FN_LSL  = 3'd3;
    localparam logic [FN_W-1:0] FN_NEG  = 3'd4;
endpackage

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [FN_W-1:0]  fn,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] c,
    output logic             c_we
);
    always_comb begin
        c    = '0;
        c_we = 1'b1;
        unique case (fn)
            FN_OR:   c = a | b;
            FN_NAND: c = ~(a & b);
            FN_NOR:  c = ~(a | b);
            FN_AND:  c = a & b;
            FN_XNOR: c = ~(a ^ b);
            FN_XOR:  c = a ^ b;
            FN_NOT:  c = ~a;
            default: c_we = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu8_arith_unit.sv
module alu8_arith_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [FN_W-1:0]  fn,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] c,
    output logic [WIDTH-1:0] d,
    output logic             c_we,
    output logic             d_we
);
    localparam int PROD_W = 2 * WIDTH;

    logic [PROD_W-1:0] prod;
    assign prod = {{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b};

    always_comb begin
        c    = '0;
        d    = '0;
        c_we = 1'b0;
        d_we = 1'b0;
        unique case (fn)
            FN_ASR: begin
                c    = {a[WIDTH-1], a[WIDTH-1:1]};
                c_we = 1'b1;
            end
            FN_MUL: begin
                c    = prod[WIDTH-1:0];
                d    = prod[PROD_W-1:WIDTH];
                c_we = 1'b1;
                d_we = 1'b1;
            end
            FN_SUB: begin
                c    = a - b;
                c_we = 1'b1;
            end
            FN_ADD: begin
                c    = a + b;
                c_we = 1'b1;
            end
            default: begin
                // divide is disabled; reserved slots write nothing
                c_we = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu8_shift_unit.sv
module alu8_shift_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [FN_W-1:0]  fn,
    input  logic [WIDTH-1:0] a,
    output logic [WIDTH-1:0] c,
    output logic             c_we
);
    always_comb begin
        c    = '0;
        c_we = 1'b1;
        unique case (fn)
            FN_ROL:  c = {a[WIDTH-2:0], a[WIDTH-1]};
            FN_ROR:  c = {a[0], a[WIDTH-1:1]};
            FN_LSR:  c = {1'b0, a[WIDTH-1:1]};
            FN_LSL:  c = {a[WIDTH-2:0], 1'b0};
            FN_NEG:  c = {WIDTH{1'b0}} - a;
            default: c_we = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu8_grouped.sv
module alu8_grouped
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [GRP_W-1:0] op_grp,
    input  logic [FN_W-1:0]  op_fn,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] res_c,
    output logic [WIDTH-1:0] res_d,
    output logic             c_we,
    output logic             d_we
);
    logic [WIDTH-1:0] lg_c, ar_c, ar_d, sh_c;
    logic             lg_we, ar_cwe, ar_dwe, sh_we;

    alu8_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .fn(op_fn), .a(opnd_a), .b(opnd_b), .c(lg_c), .c_we(lg_we)
    );

    alu8_arith_unit #(.WIDTH(WIDTH)) u_arith (
        .fn(op_fn), .a(opnd_a), .b(opnd_b),
        .c(ar_c), .d(ar_d), .c_we(ar_cwe), .d_we(ar_dwe)
    );

    alu8_shift_unit #(.WIDTH(WIDTH)) u_shift (
        .fn(op_fn), .a(opnd_a), .c(sh_c), .c_we(sh_we)
    );

    always_comb begin
        res_c = '0;
        res_d = '0;
        c_we  = 1'b0;
        d_we  = 1'b0;
        unique case (op_grp)
            GRP_LOGIC: begin
                res_c = lg_c;
                c_we  = lg_we;
            end
            GRP_ARITH: begin
                res_c = ar_c;
                res_d = ar_d;
                c_we  = ar_cwe;
                d_we  = ar_dwe;
            end
            GRP_SHIFT: begin
                res_c = sh_c;
                c_we  = sh_we;
            end
            default: begin
                // groups 3..7 are no-ops
                c_we = 1'b0;
            end
        endcase
    end

    // guards on the selected result
    always_comb begin
        if (!$isunknown({op_grp, op_fn, opnd_a, opnd_b})) begin
            AST_D_ONLY_MUL: assert (!d_we || (op_grp == GRP_ARITH && op_fn == FN_MUL)); // R4
            AST_D_ZERO_IDLE: assert (d_we || res_d == '0); // R11
            AST_C_ZERO_IDLE: assert (c_we || res_c == '0); // R11
            AST_DIV_SILENT: assert (!(op_grp == GRP_ARITH && op_fn == FN_DIV) || (!c_we && !d_we)); // R9
            AST_HIGH_GRP_NOP: assert (op_grp <= GRP_SHIFT || (!c_we && !d_we)); // R10
            AST_SUB_INVERTS: assert (!(op_grp == GRP_ARITH && op_fn == FN_SUB) || WIDTH'(res_c + opnd_b) == opnd_a); // R3
            AST_ADD_INVERTS: assert (!(op_grp == GRP_ARITH && op_fn == FN_ADD) || WIDTH'(res_c - opnd_b) == opnd_a); // R2
        end
    end
endmodule

// File: tb/tb_alu8_grouped.sv
module tb_alu8_grouped;
    typedef struct {
        logic [2:0] g;
        logic [2:0] f;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] c;
        logic [7:0] d;
        logic       cwe;
        logic       dwe;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_grp = '0;
    logic [2:0] op_fn = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic [7:0] res_c, res_d;
    logic       c_we, d_we;

    int errors = 0;
    int checks = 0;
    item_t q[$];
    logic done = 1'b0;

    always #5 clk = ~clk;

    alu8_grouped dut (
        .op_grp(op_grp), .op_fn(op_fn), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .res_c(res_c), .res_d(res_d), .c_we(c_we), .d_we(d_we)
    );

    // reference model written from the requirement list
    function automatic item_t model(input logic [2:0] g, input logic [2:0] f,
                                    input logic [7:0] a, input logic [7:0] b);
        item_t it;
        logic [15:0] p;
        it.g = g; it.f = f; it.a = a; it.b = b;
        it.c = 8'h00; it.d = 8'h00; it.cwe = 1'b0; it.dwe = 1'b0;
        it.tag = "R10";
        p = 16'(a) * 16'(b);
        if (g == 3'd0 && f != 3'd7) begin
            it.cwe = 1'b1; it.tag = "R1";
            case (f)
                3'd0: it.c = a | b;
                3'd1: it.c = ~(a & b);
                3'd2: it.c = ~(a | b);
                3'd3: it.c = a & b;
                3'd4: it.c = ~(a ^ b);
                3'd5: it.c = a ^ b;
                default: it.c = ~a;
            endcase
        end else if (g == 3'd1) begin
            case (f)
                3'd0: begin it.c = {a[7], a[7:1]}; it.cwe = 1'b1; it.tag = "R5"; end
                3'd1: it.tag = "R9";
                3'd2: begin it.c = p[7:0]; it.d = p[15:8]; it.cwe = 1'b1; it.dwe = 1'b1; it.tag = "R4"; end
                3'd3: begin it.c = a - b; it.cwe = 1'b1; it.tag = "R3"; end
                3'd4: begin it.c = a + b; it.cwe = 1'b1; it.tag = "R2"; end
                default: it.tag = "R10";
            endcase
        end else if (g == 3'd2) begin
            case (f)
                3'd0: begin it.c = {a[6:0], a[7]}; it.cwe = 1'b1; it.tag = "R6"; end
                3'd1: begin it.c = {a[0], a[7:1]}; it.cwe = 1'b1; it.tag = "R6"; end
                3'd2: begin it.c = {1'b0, a[7:1]}; it.cwe = 1'b1; it.tag = "R7"; end
                3'd3: begin it.c = {a[6:0], 1'b0}; it.cwe = 1'b1; it.tag = "R7"; end
                3'd4: begin it.c = 8'h00 - a; it.cwe = 1'b1; it.tag = "R8"; end
                default: it.tag = "R10";
            endcase
        end
        return it;
    endfunction

    // driver: apply on the falling edge and queue the expectation
    task automatic apply(input logic [2:0] g, input logic [2:0] f,
                         input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        op_grp = g; op_fn = f; opnd_a = a; opnd_b = b;
        q.push_back(model(g, f, a, b));
    endtask

    // monitor: outputs are settled half a period after the change
    always @(posedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            checks++;
            if (res_c !== e.c || res_d !== e.d || c_we !== e.cwe || d_we !== e.dwe) begin
                errors++;
                $display("FAIL %s g=%0d f=%0d a=%h b=%h: actual c=%h d=%h cwe=%b dwe=%b expected c=%h d=%h cwe=%b dwe=%b",
                         e.tag, e.g, e.f, e.a, e.b, res_c, res_d, c_we, d_we,
                         e.c, e.d, e.cwe, e.dwe);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL all: watchdog expired, actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        lfsr = 8'h5B;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero inputs select group 0 function 0 -> 0|0 (R1)
        apply(3'd0, 3'd0, 8'h00, 8'h00);
        // R1 logic patterns
        for (int f = 0; f < 8; f++) begin
            apply(3'd0, 3'(f), 8'h00, 8'hFF);
            apply(3'd0, 3'(f), 8'hA5, 8'h3C);
        end
        // R2 add wrap, R3 subtract borrow
        apply(3'd1, 3'd4, 8'hFF, 8'h01);
        apply(3'd1, 3'd4, 8'h7F, 8'h01);
        apply(3'd1, 3'd3, 8'h00, 8'h01);
        apply(3'd1, 3'd3, 8'h32, 8'h05);
        // R4 multiply high byte
        apply(3'd1, 3'd2, 8'hFF, 8'hFF);
        apply(3'd1, 3'd2, 8'h10, 8'h10);
        apply(3'd1, 3'd2, 8'h03, 8'h05);
        // R5 arithmetic shift keeps sign
        apply(3'd1, 3'd0, 8'h80, 8'h00);
        apply(3'd1, 3'd0, 8'h41, 8'hFF);
        // R9 divide writes nothing
        apply(3'd1, 3'd1, 8'h64, 8'h05);
        // R6, R7, R8 with edge bits set
        for (int f = 0; f < 8; f++) begin
            apply(3'd2, 3'(f), 8'h80, 8'h00);
            apply(3'd2, 3'(f), 8'h01, 8'hAA);
        end
        // R10 groups 3..7, R11 idle outputs
        for (int g = 3; g < 8; g++)
            for (int f = 0; f < 8; f++)
                apply(3'(g), 3'(f), 8'hFF, 8'hFF);
        // pseudo-random sweep over all codes
        for (int i = 0; i < 512; i++) begin
            logic [7:0] ra, rb;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            ra = lfsr;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rb = lfsr;
            apply(3'(i >> 3), 3'(i), ra, rb);
        end
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule